// File: doc/BRIEF.md
# Adaptive Test Item Sequencer

This block administers one multiple-choice test. It decides which item the student sees next, compares every response with the correct answer for the current item, gives right/wrong feedback where the selected strategy calls for it, and keeps a score plus a record of the items missed. The correct answer is not stored here. The block shows the current item number, and an external lookup returns that item's answer on `key_ans` in the same cycle.

A test begins with a one-cycle `start` pulse that captures the test length and one of five ordering strategies:
- plain sequential;
- sequential with feedback;
- mastery, which repeats an item until it is answered correctly;
- mastery with a closing review of missed items;
- flexilevel, in which items are ranked by difficulty and the test opens at the middle item, then steps up after a correct answer and down after a wrong one.

Top module: `item_sequencer`

## Requirements
- R1: After reset the outputs are as follows: `item_idx`=0, `done`=0, `fb_valid`=0, `cfg_err`=0, `score`=0 and `missed`=0.
- R2: A `start` whose strategy code is outside 1..5, or whose length is 0 or greater than MAX_ITEMS, sets `cfg_err`=1, `item_idx`=0 and `done`=0. It also clears `score` and `missed`. The block then stays idle until a valid `start` arrives.
- R3: Strategy 1 presents items 1..N in order and takes one response per item. `fb_valid` is never raised. `done` rises with the response to item N.
- R4: Strategy 2 presents items in order with one response each. Responses and `key_ans` both use the codes 1..5 for choices A..E. A response is correct when its code equals `key_ans`. In the cycle after each response, `fb_valid`=1 and `fb_correct` shows whether the response was correct.
- R5: Strategy 3 gives feedback and keeps the same item after a wrong response. It advances only after a correct one, and `done` rises when item N is answered correctly.
- R6: Strategy 4 runs like strategy 3. After item N is answered correctly, it presents each item whose first attempt was wrong, in ascending order. Each of these is repeated until it is answered correctly. `done` rises when no such item remains, or at once if none was missed.
- R7: Strategy 5 opens at item N/2 when N is even and at (N+1)/2 when N is odd.
- R8: In strategy 5, each item is asked once. A correct response moves to one above the highest item asked so far. A wrong response moves to one below the lowest item asked so far.
- R9: Strategy 5 ends (`done`=1) with the response to item 1 or to item N.
- R10: `score` counts items answered correctly on their first attempt. Bit k-1 of `missed` is set exactly when the first attempt at item k was wrong. Responses during the strategy 4 review change neither output.
- R11: A response while idle or done has no effect: `item_idx`, `score`, `missed` and `done` stay unchanged, and `fb_valid` stays 0.
- R12: A valid `start` restarts the test at any time. It clears `score`, `missed` and `cfg_err` and presents the strategy's first item.
- R13: A length equal to MAX_ITEMS (64 by default) is accepted and runs to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Captures length and strategy; begins a test |
| test_len | input | IW | Number of items N |
| strategy | input | 3 | Strategy code 1..5 |
| key_ans | input | 3 | Correct choice (1..5) for the item on `item_idx` |
| resp_valid | input | 1 | Response strobe |
| resp_choice | input | 3 | Chosen answer, 1..5 for A..E |
| item_idx | output | IW | Item presented, 1-based; 0 when idle |
| fb_valid | output | 1 | Feedback valid, one cycle after a response |
| fb_correct | output | 1 | Last response was correct |
| done | output | 1 | Test finished |
| cfg_err | output | 1 | Last start carried an invalid configuration |
| score | output | IW | First-attempt correct count |
| missed | output | MAX_ITEMS | Bit k-1 set when item k was missed first time |

## Verification
Every result is registered at the same edge that samples `resp_valid`. Item, feedback, done, score and missed are therefore all due one edge after a response, and a configuration error is due one edge after `start`. The driver applies each response on a falling edge and queues its expected result. The monitor pops and compares that result 2 ns after the next rising edge, so each comparison sees exactly one registered update.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {S_IDLE, S_MAIN, S_REVIEW, S_DONE} seq_state_e;

  localparam logic [2:0] ST_PLAIN    = 3'd1;
  localparam logic [2:0] ST_FEEDBACK = 3'd2;
  localparam logic [2:0] ST_MASTERY  = 3'd3;
  localparam logic [2:0] ST_REVIEW   = 3'd4;
  localparam logic [2:0] ST_FLEXI    = 3'd5;

  function automatic logic strat_known(input logic [2:0] s);
    return (s >= ST_PLAIN) && (s <= ST_FLEXI);
  endfunction

endpackage

// File: rtl/seq_tally.sv
module seq_tally #(
  parameter int N_MAX = 64,
  parameter int IW    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             first_try,
  input  logic             hit,
  input  logic             fix_done,
  input  logic [IW-1:0]    item,
  output logic [IW-1:0]    score,
  output logic [N_MAX-1:0] missed,
  output logic [IW-1:0]    first_pend,
  output logic [IW-1:0]    next_pend
);

  logic [IW-1:0]    score_q;
  logic [N_MAX-1:0] missed_q, pend_q, cur_bit;

  function automatic logic [IW-1:0] lowest_item(input logic [N_MAX-1:0] m);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N_MAX - 1; i >= 0; i--)
      if (m[i]) r = IW'(i + 1);
    return r;
  endfunction

  assign cur_bit    = (item == '0) ? '0 : (N_MAX'(1) << (item - 1'b1));
  assign first_pend = lowest_item(pend_q);
  assign next_pend  = lowest_item(pend_q & ~cur_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      score_q  <= '0;
      missed_q <= '0;
      pend_q   <= '0;
    end else if (clear) begin
      score_q  <= '0;
      missed_q <= '0;
      pend_q   <= '0;
    end else begin
      if (first_try && hit) score_q <= score_q + 1'b1;
      if (first_try && !hit) begin
        missed_q <= missed_q | cur_bit;
        pend_q   <= pend_q | cur_bit;
      end else if (fix_done) begin
        pend_q <= pend_q & ~cur_bit;
      end
    end
  end

  assign score  = score_q;
  assign missed = missed_q;

  assert_score_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (score == $past(score)) || (score == $past(score) + 1'b1));
  assert_missed_grow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (missed & $past(missed)) == $past(missed));

endmodule

// File: rtl/seq_flexi.sv
module seq_flexi #(
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [IW-1:0] mid,
  input  logic          step,
  input  logic          hit,
  output logic [IW-1:0] up_item,
  output logic [IW-1:0] dn_item
);

  logic [IW-1:0] lo_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (load) begin
      lo_q <= mid;
      hi_q <= mid;
    end else if (step) begin
      if (hit) hi_q <= hi_q + 1'b1;
      else     lo_q <= lo_q - 1'b1;
    end
  end

  assign up_item = hi_q + 1'b1;
  assign dn_item = lo_q - 1'b1;

  assert_flexi_span_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> (hi_q - lo_q) == ($past(hi_q) - $past(lo_q) + 1'b1));

endmodule

// File: rtl/item_sequencer.sv
module item_sequencer import seq_pkg::*; #(
  parameter int  MAX_ITEMS = 64,
  localparam int IW        = $clog2(MAX_ITEMS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [IW-1:0]        test_len,
  input  logic [2:0]           strategy,
  input  logic [2:0]           key_ans,
  input  logic                 resp_valid,
  input  logic [2:0]           resp_choice,
  output logic [IW-1:0]        item_idx,
  output logic                 fb_valid,
  output logic                 fb_correct,
  output logic                 done,
  output logic                 cfg_err,
  output logic [IW-1:0]        score,
  output logic [MAX_ITEMS-1:0] missed
);

  seq_state_e    state_q;
  logic [IW-1:0] len_q, item_q;
  logic [2:0]    strat_q;
  logic          tried_q, cfg_err_q, fbv_q, fbc_q;

  function automatic logic [IW-1:0] middle_item(input logic [IW-1:0] n);
    logic [IW:0] w;
    w = {1'b0, n} + 1'b1;
    return w[IW:1];
  endfunction

  function automatic logic cfg_ok(input logic [2:0] s, input logic [IW-1:0] n);
    return strat_known(s) && (n != '0) && (n <= IW'(MAX_ITEMS));
  endfunction

  // named internal events
  logic asking, accept, hit, first_try, fix_done, at_last, flexi_step, launch;
  logic [IW-1:0] first_pend, next_pend, up_item, dn_item;

  assign asking     = (state_q == S_MAIN) || (state_q == S_REVIEW);
  assign accept     = resp_valid && asking && !start;
  assign hit        = accept && (resp_choice == key_ans);
  assign first_try  = accept && (state_q == S_MAIN) && !tried_q;
  assign fix_done   = hit && (state_q == S_REVIEW);
  assign at_last    = (item_q == len_q);
  assign flexi_step = accept && (strat_q == ST_FLEXI);
  assign launch     = start && cfg_ok(strategy, test_len);

  seq_tally #(.N_MAX(MAX_ITEMS), .IW(IW)) i_tally (
    .clk(clk), .rst_n(rst_n), .clear(start), .first_try(first_try), .hit(hit),
    .fix_done(fix_done), .item(item_q), .score(score), .missed(missed),
    .first_pend(first_pend), .next_pend(next_pend)
  );

  seq_flexi #(.IW(IW)) i_flexi (
    .clk(clk), .rst_n(rst_n), .load(launch), .mid(middle_item(test_len)),
    .step(flexi_step), .hit(hit), .up_item(up_item), .dn_item(dn_item)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      len_q     <= '0;
      item_q    <= '0;
      strat_q   <= ST_PLAIN;
      tried_q   <= 1'b0;
      cfg_err_q <= 1'b0;
      fbv_q     <= 1'b0;
      fbc_q     <= 1'b0;
    end else begin
      fbv_q <= accept && (strat_q != ST_PLAIN);
      fbc_q <= hit;
      if (start) begin
        tried_q <= 1'b0;
        if (launch) begin
          cfg_err_q <= 1'b0;
          len_q     <= test_len;
          strat_q   <= strategy;
          state_q   <= S_MAIN;
          item_q    <= (strategy == ST_FLEXI) ? middle_item(test_len) : IW'(1);
        end else begin
          cfg_err_q <= 1'b1;
          state_q   <= S_IDLE;
          item_q    <= '0;
        end
      end else if (accept) begin
        if (state_q == S_REVIEW) begin
          if (hit) begin
            if (next_pend != '0) item_q <= next_pend;
            else                 state_q <= S_DONE;
          end
        end else begin
          case (strat_q)
            ST_FLEXI: begin
              if (item_q == IW'(1) || at_last) state_q <= S_DONE;
              else item_q <= hit ? up_item : dn_item;
            end
            ST_MASTERY, ST_REVIEW: begin
              if (!hit) begin
                tried_q <= 1'b1;
              end else begin
                tried_q <= 1'b0;
                if (!at_last) begin
                  item_q <= item_q + 1'b1;
                end else if (strat_q == ST_REVIEW && first_pend != '0) begin
                  state_q <= S_REVIEW;
                  item_q  <= first_pend;
                end else begin
                  state_q <= S_DONE;
                end
              end
            end
            default: begin
              if (at_last) state_q <= S_DONE;
              else         item_q  <= item_q + 1'b1;
            end
          endcase
        end
      end
    end
  end

  assign item_idx   = item_q;
  assign fb_valid   = fbv_q;
  assign fb_correct = fbc_q;
  assign done       = (state_q == S_DONE);
  assign cfg_err    = cfg_err_q;

  assert_cfg_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !cfg_ok(strategy, test_len) |=> cfg_err && !done && item_idx == '0);
  assert_item_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    asking |-> (item_idx >= IW'(1)) && (item_idx <= len_q));
  assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(score) && $stable(missed));
  assert_plain_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid |-> strat_q != ST_PLAIN);
  assert_review_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_REVIEW |-> strat_q == ST_REVIEW);

endmodule

// File: tb/test_item_sequencer.sv
module test_item_sequencer;

  localparam int MAXN = 64;
  localparam int IW   = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic            rst_n = 1'b0, start = 1'b0, resp_valid = 1'b0;
  logic [IW-1:0]   test_len = '0;
  logic [2:0]      strategy = '0, resp_choice = '0, key_ans;
  logic [IW-1:0]   item_idx, score;
  logic            fb_valid, fb_correct, done, cfg_err;
  logic [MAXN-1:0] missed;

  item_sequencer #(.MAX_ITEMS(MAXN)) i_item_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .test_len(test_len), .strategy(strategy),
    .key_ans(key_ans), .resp_valid(resp_valid), .resp_choice(resp_choice),
    .item_idx(item_idx), .fb_valid(fb_valid), .fb_correct(fb_correct), .done(done),
    .cfg_err(cfg_err), .score(score), .missed(missed)
  );

  function automatic logic [2:0] key_of(input int it);
    return 3'(((it * 3) % 5) + 1);
  endfunction
  assign key_ans = key_of(int'(item_idx));

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct {
    int item; bit fbv; bit fbc; bit dn; int sc; logic [MAXN-1:0] ms; string tag;
  } exp_t;
  exp_t q[$];
  exp_t e;

  // reference model
  int m_strat, m_len, m_item, m_phase;  // phase: 0 idle, 1 main, 2 review, 3 done
  bit m_tried;
  int m_score;
  logic [MAXN-1:0] m_missed;
  bit m_fix [1:MAXN];
  bit m_asked [1:MAXN];

  function automatic int first_fix();
    for (int i = 1; i <= MAXN; i++) if (m_fix[i]) return i;
    return 0;
  endfunction
  function automatic int top_asked();
    for (int i = MAXN; i >= 1; i--) if (m_asked[i]) return i;
    return 0;
  endfunction
  function automatic int bottom_asked();
    for (int i = 1; i <= MAXN; i++) if (m_asked[i]) return i;
    return 0;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per edge after a response
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (int'(item_idx) != e.item || fb_valid != e.fbv || (e.fbv && fb_correct != e.fbc) ||
          done != e.dn || int'(score) != e.sc || missed != e.ms) begin
        errors++;
        $display("FAIL %s actual item=%0d fbv=%0b fbc=%0b done=%0b score=%0d missed=%h expected item=%0d fbv=%0b fbc=%0b done=%0b score=%0d missed=%h",
                 e.tag, item_idx, fb_valid, fb_correct, done, score, missed,
                 e.item, e.fbv, e.fbc, e.dn, e.sc, e.ms);
      end
    end
  end

  task automatic begin_test(input int s, input int n, input string tag);
    bit ok;
    ok = (s >= 1 && s <= 5 && n >= 1 && n <= MAXN);
    @(negedge clk);
    start = 1'b1; strategy = 3'(s); test_len = IW'(n);
    m_strat = s; m_len = n; m_tried = 0; m_score = 0; m_missed = '0;
    for (int i = 1; i <= MAXN; i++) begin m_fix[i] = 0; m_asked[i] = 0; end
    if (ok) begin
      m_phase = 1;
      m_item = (s == 5) ? ((n % 2 == 0) ? n / 2 : (n + 1) / 2) : 1;
    end else begin
      m_phase = 0; m_item = 0;
    end
    @(negedge clk);
    start = 1'b0;
    chk({tag, " item after start"}, item_idx, m_item);
    chk({tag, " cfg_err"}, cfg_err, !ok);
    chk({tag, " done after start"}, done, 0);
    chk({tag, " score cleared R12"}, score, 0);
    chk({tag, " missed cleared R12"}, missed, 0);
  endtask

  task automatic answer(input bit right, input string tag);
    logic [2:0] k, c;
    bit ok;
    exp_t x;
    k = key_of(m_item);
    c = right ? k : 3'((int'(k) % 5) + 1);
    ok = (c == k);
    x.fbv = 0; x.fbc = 0;
    if (m_phase == 1 || m_phase == 2) begin
      x.fbv = (m_strat != 1); x.fbc = ok;
      if (m_phase == 1) begin
        if (!m_tried) begin
          if (ok) m_score++;
          else begin m_missed[m_item-1] = 1'b1; m_fix[m_item] = 1; end
        end
        if (m_strat == 5) begin
          m_asked[m_item] = 1;
          if (m_item == 1 || m_item == m_len) m_phase = 3;
          else if (ok) m_item = top_asked() + 1;
          else m_item = bottom_asked() - 1;
        end else if (m_strat <= 2) begin
          if (m_item == m_len) m_phase = 3; else m_item++;
        end else if (!ok) begin
          m_tried = 1;
        end else begin
          m_tried = 0;
          if (m_item < m_len) m_item++;
          else if (m_strat == 4 && first_fix() > 0) begin m_phase = 2; m_item = first_fix(); end
          else m_phase = 3;
        end
      end else if (ok) begin
        m_fix[m_item] = 0;
        if (first_fix() > 0) m_item = first_fix(); else m_phase = 3;
      end
    end
    x.item = m_item; x.dn = (m_phase == 3); x.sc = m_score; x.ms = m_missed; x.tag = tag;
    @(negedge clk);
    resp_valid = 1'b1; resp_choice = c;
    q.push_back(x);
    @(negedge clk);
    resp_valid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_phase = 0; m_item = 0; m_strat = 1; m_len = 0; m_score = 0; m_missed = '0; m_tried = 0;
    for (int i = 1; i <= MAXN; i++) begin m_fix[i] = 0; m_asked[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 item", item_idx, 0);
    chk("R1 done", done, 0);
    chk("R1 fb_valid", fb_valid, 0);
    chk("R1 cfg_err", cfg_err, 0);
    chk("R1 score", score, 0);
    chk("R1 missed", missed, 0);
    answer(1, "R11 response before any start");

    begin_test(0, 4, "R2 strategy 0");
    begin_test(6, 4, "R2 strategy 6");
    begin_test(2, 0, "R2 length 0");
    begin_test(2, 65, "R2 length 65");
    answer(1, "R2 R11 response while idle after error");

    begin_test(1, 4, "R3");
    answer(1, "R3 item1"); answer(0, "R3 R10 item2"); answer(1, "R3 item3"); answer(1, "R3 item4");
    answer(1, "R11 response after done");

    begin_test(2, 3, "R4");
    answer(0, "R4 item1"); answer(1, "R4 item2"); answer(0, "R4 item3");

    begin_test(3, 3, "R5");
    answer(0, "R5 item1 miss"); answer(0, "R5 item1 repeat"); answer(1, "R5 item1 fixed");
    answer(1, "R5 item2"); answer(0, "R5 R10 item3 miss"); answer(1, "R5 item3 fixed");

    begin_test(4, 5, "R6");
    answer(1, "R6 item1"); answer(0, "R6 item2 miss"); answer(1, "R6 item2 fixed");
    answer(1, "R6 item3"); answer(0, "R6 item4 miss"); answer(0, "R6 item4 again");
    answer(1, "R6 item4 fixed"); answer(0, "R6 item5 miss"); answer(1, "R6 enter review");
    answer(0, "R6 R10 review item2 wrong"); answer(1, "R6 review item2");
    answer(1, "R6 review item4"); answer(1, "R6 review item5 done");
    begin_test(4, 2, "R6 clean");
    answer(1, "R6 clean item1"); answer(1, "R6 clean no review");

    begin_test(5, 8, "R7 even");
    answer(1, "R8 up"); answer(1, "R8 up"); answer(0, "R8 down below lowest");
    answer(0, "R8 down"); answer(1, "R8 up above highest"); answer(1, "R8 up to top");
    answer(0, "R9 end at top item");
    begin_test(5, 7, "R7 odd");
    answer(0, "R8 down"); answer(0, "R8 down"); answer(0, "R8 down to item1");
    answer(1, "R9 end at item1");
    begin_test(5, 1, "R7 R9 single");
    answer(0, "R9 single item ends");

    begin_test(2, 4, "R12 first");
    answer(0, "R12 before restart");
    begin_test(3, 2, "R12 restart");
    answer(1, "R12 after restart");

    begin_test(2, MAXN, "R13");
    for (int i = 1; i <= MAXN; i++) answer(i % 8 != 0, "R13 long test");

    repeat (3) @(negedge clk);
    chk("R13 queue drained", q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule